// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

This block decides, once per clock, whether a processor core should be offered a hard interrupt, and with which trap code. It combines fifteen level-sensitive external request lines, the software-interrupt register and the two timer-match flags into one set of pending levels. It then weighs that set against the core's current priority level, the global interrupt enable and the trap currently being serviced. From that it raises, holds or withdraws a single request and stores the trap code that goes with it.

A separate vector-interrupt port takes precedence over every level. Raising it while it is idle marks it busy and loads the vector trap code. It also fills three data words that the core reads when it enters the trap. While the port is busy, level arbitration is frozen. Lowering the port releases it and withdraws the request. All outputs come from registers, so every decision appears one clock after the inputs that caused it. Trap entry itself belongs to the core.

Top module: `pil_arbiter`

## Requirements
- R1: Level i (1..15) is pending when `ext_irq[i]` or `soft_int[i]` is set. The timer flags `soft_int[0]` (tick match) and `soft_int[16]` (system tick match) never make a level pending at their own positions.
- R2: When `soft_int[0]` or `soft_int[16]` is set, level 14 is pending.
- R3: When the port is idle and not being raised, and no pending level is strictly above `cur_pil`, the next cycle shows `irq_req`=0 and `trap_code`=0. With `cur_pil`=15 this always holds.
- R4: When the port is idle and interrupts are enabled, the highest pending level i above `cur_pil` wins with code 0x40|i. If that code differs from the stored code, the next cycle shows `irq_req`=1 with that code. An equal code leaves both outputs unchanged.
- R5: When `trap_lvl`>0, `top_tt[8:4]`=5'h04 and `top_tt` is numerically greater than the winning code, the request and code keep their previous values.
- R6: When `int_en`=0 with the port idle and not being raised, the next cycle shows `irq_req`=0 and `trap_code`=0.
- R7: A `vec_raise` while the port is idle sets `vec_busy`=1, `irq_req`=1 and `trap_code`=0x60. In the same clock `vec_word0` becomes 0x7C0|`vec_irq_id`, and `vec_word1` and `vec_word2` become 0.
- R8: A `vec_raise` while the port is busy changes nothing: the data words, the code and the request keep their values.
- R9: While the port is busy and `vec_lower` is low, the level inputs have no effect: `irq_req`, `trap_code` and the data words stay stable.
- R10: A `vec_lower` while the port is busy clears `vec_busy` and `irq_req` and leaves `trap_code` unchanged. A `vec_lower` while the port is idle is ignored.
- R11: A synchronous reset (`rst`=1) clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 15 | External level lines, bits 15:1 = levels 15..1 |
| soft_int | input | 17 | Soft interrupts: bits 15:1 levels, bit 0 tick match, bit 16 system tick match |
| cur_pil | input | 4 | Current processor priority level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| top_tt | input | 9 | Trap code at the top of the trap stack |
| vec_raise | input | 1 | Raise the vector interrupt |
| vec_lower | input | 1 | Lower the vector interrupt |
| vec_irq_id | input | 6 | Vector interrupt number loaded into data word 0 |
| irq_req | output | 1 | Hard-interrupt request to the core |
| trap_code | output | 9 | Trap code for the request |
| vec_busy | output | 1 | Vector interrupt outstanding |
| vec_word0 | output | 64 | Vector data word 0 |
| vec_word1 | output | 64 | Vector data word 1 |
| vec_word2 | output | 64 | Vector data word 2 |

## Verification
The embedded properties check the cycle-level rules on every clock. A busy vector port freezes the outputs, and an accepted raise or lower takes effect on the next cycle. A disabled core or a pending set with nothing above the priority level always ends with a cleared request. A repeated raise leaves the data words alone. Which level wins, the folding of the timer flags into level 14, and the suppression by a higher external trap already in service depend on the whole pending set and the trap state. Only the bench's reference model, compared on every cycle across the directed scenarios, shows these.

// File: rtl/pil_arb_pkg.sv
package pil_arb_pkg;
  // Trap code base for level interrupts; the level number fills the low bits.
  localparam int unsigned EXT_BASE_CODE = 'h040;
  // Trap code reported for the vector interrupt.
  localparam int unsigned VEC_TRAP_CODE = 'h060;
  // Tag placed above the interrupt number in vector data word 0.
  localparam int unsigned VEC_TAG_W     = 5;
  localparam int unsigned VEC_TAG_VAL   = 'h1F;

  typedef enum logic [1:0] {
    ARB_HOLD  = 2'd0,
    ARB_CLEAR = 2'd1,
    ARB_RAISE = 2'd2
  } arb_act_e;
endpackage

// File: rtl/pil_pending_merge.sv
module pil_pending_merge #(
  parameter int unsigned NUM_LVL   = 16,
  parameter int unsigned TIMER_LVL = 14
) (
  input  logic [NUM_LVL-1:1] ext_irq,
  input  logic [NUM_LVL:0]   soft_int,
  output logic [NUM_LVL-1:1] pend
);
  // Bit 0 and bit NUM_LVL of soft_int are the timer-match flags.
  logic timer_hit;
  assign timer_hit = soft_int[0] | soft_int[NUM_LVL];

  for (genvar g = 1; g < NUM_LVL; g++) begin : g_lvl
    if (g == TIMER_LVL) begin : g_timer
      assign pend[g] = ext_irq[g] | soft_int[g] | timer_hit;
    end else begin : g_plain
      assign pend[g] = ext_irq[g] | soft_int[g];
    end
  end
endmodule

// File: rtl/pil_level_pick.sv
module pil_level_pick #(
  parameter int unsigned NUM_LVL = 16,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:1] pend,
  input  logic [LVL_W-1:0]   cur_pil,
  output logic               any_above,
  output logic [LVL_W-1:0]   win_lvl
);
  // Ascending scan: the last qualifying level overwrites, so the highest wins.
  always_comb begin
    any_above = 1'b0;
    win_lvl   = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (pend[i] && (LVL_W'(i) > cur_pil)) begin
        any_above = 1'b1;
        win_lvl   = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/pil_vec_port.sv
module pil_vec_port #(
  parameter int unsigned VEC_ID_W = 6,
  parameter int unsigned DATA_W   = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vec_raise,
  input  logic                vec_lower,
  input  logic [VEC_ID_W-1:0] vec_irq_id,
  output logic                busy,
  output logic                raise_acc,
  output logic                lower_acc,
  output logic [DATA_W-1:0]   word0,
  output logic [DATA_W-1:0]   word1,
  output logic [DATA_W-1:0]   word2
);
  import pil_arb_pkg::*;

  localparam int unsigned PAD_W = DATA_W - VEC_TAG_W - VEC_ID_W;
  localparam logic [VEC_TAG_W-1:0] TAG = VEC_TAG_W'(VEC_TAG_VAL);

  assign raise_acc = vec_raise & ~busy;
  assign lower_acc = vec_lower & busy & ~vec_raise;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      word0 <= '0;
      word1 <= '0;
      word2 <= '0;
    end else if (raise_acc) begin
      busy  <= 1'b1;
      word0 <= {{PAD_W{1'b0}}, TAG, vec_irq_id};
      word1 <= '0;
      word2 <= '0;
    end else if (lower_acc) begin
      busy  <= 1'b0;
    end
  end

  // R8: a raise while busy leaves the data words untouched
  p_raise_busy_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && vec_raise) |=> ($stable(word0) && $stable(word1) && $stable(word2)));

  // R7: an accepted raise clears the upper data words
  p_raise_clears_words_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && vec_raise) |=> (busy && word1 == '0 && word2 == '0));
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter #(
  parameter int unsigned NUM_LVL   = 16,
  parameter int unsigned TIMER_LVL = 14,
  parameter int unsigned CODE_W    = 9,
  parameter int unsigned TL_W      = 3,
  parameter int unsigned VEC_ID_W  = 6,
  parameter int unsigned DATA_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LVL-1:1]   ext_irq,
  input  logic [NUM_LVL:0]     soft_int,
  input  logic [$clog2(NUM_LVL)-1:0] cur_pil,
  input  logic                 int_en,
  input  logic [TL_W-1:0]      trap_lvl,
  input  logic [CODE_W-1:0]    top_tt,
  input  logic                 vec_raise,
  input  logic                 vec_lower,
  input  logic [VEC_ID_W-1:0]  vec_irq_id,
  output logic                 irq_req,
  output logic [CODE_W-1:0]    trap_code,
  output logic                 vec_busy,
  output logic [DATA_W-1:0]    vec_word0,
  output logic [DATA_W-1:0]    vec_word1,
  output logic [DATA_W-1:0]    vec_word2
);
  import pil_arb_pkg::*;

  localparam int unsigned LVL_W = $clog2(NUM_LVL);
  localparam logic [CODE_W-1:0] EXT_CODE = CODE_W'(EXT_BASE_CODE);
  localparam logic [CODE_W-1:0] VEC_CODE = CODE_W'(VEC_TRAP_CODE);

  logic [NUM_LVL-1:1] pend;
  logic               any_above;
  logic [LVL_W-1:0]   win_lvl;
  logic               raise_acc, lower_acc;
  logic [CODE_W-1:0]  new_code;
  logic               suppress;
  arb_act_e           act;
  logic               req_d;
  logic [CODE_W-1:0]  code_d;

  pil_pending_merge #(.NUM_LVL(NUM_LVL), .TIMER_LVL(TIMER_LVL)) u_merge (
    .ext_irq  (ext_irq),
    .soft_int (soft_int),
    .pend     (pend)
  );

  pil_level_pick #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_pick (
    .pend      (pend),
    .cur_pil   (cur_pil),
    .any_above (any_above),
    .win_lvl   (win_lvl)
  );

  pil_vec_port #(.VEC_ID_W(VEC_ID_W), .DATA_W(DATA_W)) u_vec (
    .clk        (clk),
    .rst        (rst),
    .vec_raise  (vec_raise),
    .vec_lower  (vec_lower),
    .vec_irq_id (vec_irq_id),
    .busy       (vec_busy),
    .raise_acc  (raise_acc),
    .lower_acc  (lower_acc),
    .word0      (vec_word0),
    .word1      (vec_word1),
    .word2      (vec_word2)
  );

  assign new_code = EXT_CODE | CODE_W'(win_lvl);

  // A higher external trap already in service blocks the new level.
  assign suppress = (trap_lvl != '0)
                 && (top_tt[CODE_W-1:4] == EXT_CODE[CODE_W-1:4])
                 && (top_tt > new_code);

  always_comb begin
    if (!any_above || !int_en)              act = ARB_CLEAR;
    else if (!suppress && trap_code != new_code) act = ARB_RAISE;
    else                                     act = ARB_HOLD;
  end

  always_comb begin
    req_d  = irq_req;
    code_d = trap_code;
    if (raise_acc) begin
      req_d  = 1'b1;
      code_d = VEC_CODE;
    end else if (lower_acc) begin
      req_d  = 1'b0;
    end else if (!vec_busy) begin
      case (act)
        ARB_CLEAR: begin req_d = 1'b0; code_d = '0;       end
        ARB_RAISE: begin req_d = 1'b1; code_d = new_code; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      trap_code <= '0;
    end else begin
      irq_req   <= req_d;
      trap_code <= code_d;
    end
  end

  // R9: a busy vector port freezes the level outputs
  p_busy_freezes_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_busy && !vec_lower) |=> ($stable(irq_req) && $stable(trap_code)));

  // R7: an accepted raise yields the vector code with the request set
  p_vec_raise_r7: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && vec_raise) |=> (irq_req && vec_busy && trap_code == VEC_CODE));

  // R10: lowering a busy port withdraws the request but keeps the code
  p_vec_lower_r10: assert property (@(posedge clk) disable iff (rst)
    (vec_busy && vec_lower && !vec_raise) |=>
      (!vec_busy && !irq_req && $stable(trap_code)));

  // R6: disabled interrupts clear request and code
  p_disabled_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && !vec_raise && !int_en) |=> (!irq_req && trap_code == '0));

  // R3: nothing above the priority level clears request and code
  p_below_level_r3: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && !vec_raise && !any_above) |=> (!irq_req && trap_code == '0));

  // R4: an active request always carries a level code or the vector code
  p_req_has_code_r4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((trap_code[CODE_W-1:4] == EXT_CODE[CODE_W-1:4]
                  && trap_code[3:0] != '0) || trap_code == VEC_CODE));
endmodule

// File: tb/pil_arbiter_tb.sv
module pil_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] ext_irq = '0;
  logic [16:0] soft_int = '0;
  logic [3:0]  cur_pil = '0;
  logic        int_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  top_tt = '0;
  logic        vec_raise = 1'b0;
  logic        vec_lower = 1'b0;
  logic [5:0]  vec_irq_id = '0;
  logic        irq_req;
  logic [8:0]  trap_code;
  logic        vec_busy;
  logic [63:0] vec_word0, vec_word1, vec_word2;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference model state
  bit          m_req;
  int          m_code;
  bit          m_busy;
  longint      m_w0, m_w1, m_w2;

  always #2.5 clk = ~clk;

  pil_arbiter u_dut (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .soft_int(soft_int),
    .cur_pil(cur_pil), .int_en(int_en), .trap_lvl(trap_lvl),
    .top_tt(top_tt), .vec_raise(vec_raise), .vec_lower(vec_lower),
    .vec_irq_id(vec_irq_id), .irq_req(irq_req), .trap_code(trap_code),
    .vec_busy(vec_busy), .vec_word0(vec_word0), .vec_word1(vec_word1),
    .vec_word2(vec_word2)
  );

  function automatic int pending_set();
    int p = 0;
    for (int i = 1; i <= 15; i++)
      if (ext_irq[i] || soft_int[i]) p = p | (1 << i);
    if (soft_int[0] || soft_int[16]) p = p | (1 << 14);
    return p;
  endfunction

  task automatic model_update();
    int p;
    if (rst) begin
      m_req = 0; m_code = 0; m_busy = 0; m_w0 = 0; m_w1 = 0; m_w2 = 0;
      return;
    end
    p = pending_set();
    if (vec_raise && !m_busy) begin
      m_busy = 1; m_req = 1; m_code = 'h60;
      m_w0 = 64'h7C0 | longint'(vec_irq_id); m_w1 = 0; m_w2 = 0;
    end else if (vec_lower && m_busy) begin
      m_busy = 0; m_req = 0;
    end else if (!m_busy) begin
      if (p < (2 << int'(cur_pil)) || !int_en) begin
        m_req = 0; m_code = 0;
      end else begin
        for (int i = 15; i > int'(cur_pil); i--) begin
          if (p[i]) begin
            int nc = 'h40 | i;
            if (!(trap_lvl != 0 && top_tt[8:4] == 5'h04 && int'(top_tt) > nc)
                && m_code != nc) begin
              m_code = nc; m_req = 1;
            end
            break;
          end
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (irq_req !== m_req || int'(trap_code) != m_code || vec_busy !== m_busy
        || vec_word0 !== m_w0 || vec_word1 !== m_w1 || vec_word2 !== m_w2) begin
      n_fail++;
      $display("FAIL %s cycle compare: req=%0b code=%03h busy=%0b w0=%016h w1=%016h w2=%016h expected req=%0b code=%03h busy=%0b w0=%016h w1=%016h w2=%016h",
               tag, irq_req, trap_code, vec_busy, vec_word0, vec_word1, vec_word2,
               m_req, m_code, m_busy, m_w0, m_w1, m_w2);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    #1;
    compare(tag);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    // R11: reset state
    rst = 1'b1;
    step("R11"); step("R11");
    chk("R11 req", irq_req, 0);
    chk("R11 code", trap_code, 0);
    chk("R11 busy", vec_busy, 0);
    chk("R11 word0", vec_word0, 0);
    rst = 1'b0;

    // R4: highest pending level above the priority level wins
    int_en = 1; cur_pil = 3; ext_irq = '0; ext_irq[5] = 1; ext_irq[9] = 1;
    step("R4"); step("R4");
    chk("R4 code", trap_code, 'h49);
    chk("R4 req", irq_req, 1);

    // R1: soft bits act as levels; timer flags do not light their own positions
    ext_irq = '0; soft_int = '0; soft_int[11] = 1;
    step("R1");
    chk("R1 soft level", trap_code, 'h4B);
    soft_int = '0; soft_int[0] = 1; cur_pil = 14;
    step("R1");
    chk("R1 tick not above 14", irq_req, 0);

    // R2: timer flags fold into level 14
    cur_pil = 3;
    step("R2");
    chk("R2 tick match", trap_code, 'h4E);
    soft_int = '0; soft_int[16] = 1; ext_irq[2] = 1;
    step("R2"); step("R2");
    chk("R2 system tick match", trap_code, 'h4E);

    // R3: nothing above level clears
    soft_int = '0; ext_irq = '0; ext_irq[9] = 1; cur_pil = 12;
    step("R3");
    chk("R3 below level", irq_req, 0);
    chk("R3 code cleared", trap_code, 0);
    ext_irq = '1; soft_int = '1; cur_pil = 15;
    step("R3"); step("R3");
    chk("R3 level 15", irq_req, 0);

    // R6: globally disabled clears an active request
    soft_int = '0; ext_irq = '0; ext_irq[13] = 1; cur_pil = 2;
    step("R6");
    chk("R6 raised first", trap_code, 'h4D);
    int_en = 0;
    step("R6");
    chk("R6 disabled req", irq_req, 0);
    chk("R6 disabled code", trap_code, 0);

    // R5: higher external trap in service suppresses
    int_en = 1; ext_irq = '0; ext_irq[9] = 1; cur_pil = 3;
    trap_lvl = 1; top_tt = 9'h04D;
    step("R5"); step("R5");
    chk("R5 suppressed", irq_req, 0);
    top_tt = 9'h048;
    step("R5");
    chk("R5 lower trap allows", trap_code, 'h49);
    top_tt = 9'h05D; ext_irq[10] = 1;
    step("R5");
    chk("R5 non-external trap allows", trap_code, 'h4A);
    trap_lvl = 0; top_tt = 9'h04F; ext_irq[11] = 1;
    step("R5");
    chk("R5 trap level zero allows", trap_code, 'h4B);

    // R10: lower while idle ignored
    vec_lower = 1;
    step("R10");
    vec_lower = 0;
    chk("R10 idle lower ignored", irq_req, 1);
    chk("R10 idle lower code", trap_code, 'h4B);

    // R7: vector raise
    vec_raise = 1; vec_irq_id = 6'h15;
    step("R7");
    vec_raise = 0;
    chk("R7 code", trap_code, 'h60);
    chk("R7 word0", vec_word0, 'h7D5);
    chk("R7 busy", vec_busy, 1);

    // R8: raise while busy ignored
    vec_raise = 1; vec_irq_id = 6'h03;
    step("R8");
    vec_raise = 0;
    chk("R8 word0 unchanged", vec_word0, 'h7D5);
    chk("R8 code unchanged", trap_code, 'h60);

    // R9: busy masks level inputs
    ext_irq = '0; ext_irq[15] = 1; int_en = 0;
    step("R9");
    int_en = 1;
    step("R9"); step("R9");
    chk("R9 code held", trap_code, 'h60);
    chk("R9 req held", irq_req, 1);

    // R10: lower while busy
    vec_lower = 1;
    step("R10");
    vec_lower = 0;
    chk("R10 busy cleared", vec_busy, 0);
    chk("R10 req withdrawn", irq_req, 0);
    chk("R10 code kept", trap_code, 'h60);
    step("R10");
    chk("R10 arbitration resumes", trap_code, 'h4F);
    chk("R10 arbitration req", irq_req, 1);

    // R4: equal code stays; R7 a second raise after release
    step("R4"); step("R4");
    vec_raise = 1; vec_irq_id = 6'h3F;
    step("R7");
    vec_raise = 0;
    chk("R7 second raise word0", vec_word0, 'h7FF);
    vec_lower = 1;
    step("R10");
    vec_lower = 0;
    step("R10");

    // R11: reset mid-activity
    rst = 1;
    step("R11");
    rst = 0;
    chk("R11 reset mid run", vec_word0, 0);
    ext_irq = '0;
    step("R3");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule